// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is an associative store of `DEPTH` words, each 24 bits wide by default and made of three packed fields: a 12-bit high field (bits 23:12), a 4-bit middle field (bits 11:8) and an 8-bit low field (bits 7:0). Software-side control loads a search key register and an ignore-mask register, then starts a search. The key is presented to every cell at the same moment. Each cell compares its own stored word against the key, skipping the ignored bit positions, and records the outcome in a private tag bit. A separate gathering stage reduces the tag vector to a hit flag, the lowest matching index and the number of matching entries. The result is an index, never the stored contents.

Words are written by index through a simple write port, and a write marks the entry valid. Entries that have never been written cannot match. Because the ignore mask can blank any set of bits, any field or combination of fields can serve as the key, including the empty key that matches every valid entry.

A search takes two cycles. The first edge registers the tag vector. The second edge registers the gathered result and pulses a done strobe. Writes and key or mask loads that land on or after the starting edge are seen only by later searches.

Top module: `maskedCam`

## Requirements
- R1: After reset, busy, done and hit are 0, hitIdx is 0 and hitCount is 0. Every entry is invalid, so a search after reset misses even with every bit ignored.
- R2: When wrEn is high at a clock edge, wrData is stored at entry wrIdx and that entry becomes valid. An overwrite replaces the old word, so a later search for the old value no longer finds it.
- R3: An entry matches when it is valid and its stored bit equals the key bit in every position whose ignore-mask bit is 0. A mask bit of 1 excludes that position. The fields sit at bits 23:12, 11:8 and 7:0.
- R4: With the ignore mask all ones, every valid entry matches and no invalid entry does.
- R5: A startSearch sampled while idle makes busy 1 for the next cycle. done is then 1 for exactly one cycle, starting right after the second edge. busy is 0 again in that cycle.
- R6: When done is 1, hit is 1 exactly when hitCount is nonzero. hitIdx is the lowest matching index on a hit and 0 on a miss.
- R7: hitCount is the number of matching entries and can range from 0 up to and including DEPTH.
- R8: loadKey and loadSkip update their registers at a clock edge. A search started at that same edge still uses the previous key and mask.
- R9: A write at the starting edge of a search, or during its busy cycle, does not change that search's result. Later searches see the write.
- R10: startSearch is ignored while busy. hit, hitIdx and hitCount hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| loadKey | input | 1 | Load keyIn into the search key register |
| keyIn | input | WORD_W | New search key value |
| loadSkip | input | 1 | Load skipIn into the ignore-mask register |
| skipIn | input | WORD_W | New ignore mask; 1 excludes a bit from the compare |
| startSearch | input | 1 | Begin a search (ignored while busy) |
| wrEn | input | 1 | Write enable for the storage array |
| wrIdx | input | IDX_W | Entry index to write |
| wrData | input | WORD_W | Word to store |
| busy | output | 1 | Search in its gathering cycle |
| done | output | 1 | One-cycle pulse when a result is registered |
| hit | output | 1 | At least one entry matched |
| hitIdx | output | IDX_W | Lowest matching index, 0 on a miss |
| hitCount | output | CNT_W | Number of matching entries |

## Verification
The compare is tried with a full key and no bits ignored, which separates exact matches from near misses that differ in a single field. It is also tried with whole fields ignored, which shows that entries agreeing only on the kept field are found. An all-ignored mask is run against partly filled and fully filled tables; this isolates the valid-bit gating and the count at its upper bound of DEPTH. Duplicated words at scattered indices separate lowest-index selection from simple match counting. Key loads and writes placed on the starting edge and in the busy cycle show which contents a search actually snapshots. Random field-structured words, keys and masks then cover mixed cases.

// File: rtl/maskedCamPkg.sv
package maskedCamPkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_GATHER = 1'b1
  } camState_t;

  typedef struct packed {
    logic captureTags;
    logic captureResult;
  } camStrobes_t;

endpackage

// File: rtl/camCtrl.sv
module camCtrl
  import maskedCamPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startSearch,
  output camStrobes_t strobes,
  output logic        busy,
  output logic        done
);

  camState_t state;

  always_comb begin
    strobes.captureTags   = (state == ST_IDLE) && startSearch;
    strobes.captureResult = (state == ST_GATHER);
  end

  assign busy = (state == ST_GATHER);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= strobes.captureResult;
      if (strobes.captureTags)
        state <= ST_GATHER;
      else if (strobes.captureResult)
        state <= ST_IDLE;
    end
  end

endmodule

// File: rtl/camCell.sv
module camCell #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrSel,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] keyWord,
  input  logic [WORD_W-1:0] skipWord,
  output logic              matchBit
);

  logic [WORD_W-1:0] storedWord;
  logic              entryValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storedWord <= '0;
      entryValid <= 1'b0;
    end else if (wrSel) begin
      storedWord <= wrData;
      entryValid <= 1'b1;
    end
  end

  assign matchBit = entryValid && (((storedWord ^ keyWord) & ~skipWord) == '0);

endmodule

// File: rtl/camDatapath.sv
module camDatapath
  import maskedCamPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 24,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  camStrobes_t       strobes,
  input  logic              loadKey,
  input  logic [WORD_W-1:0] keyIn,
  input  logic              loadSkip,
  input  logic [WORD_W-1:0] skipIn,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [WORD_W-1:0] wrData,
  output logic              hit,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [CNT_W-1:0]  hitCount
);

  logic [WORD_W-1:0] keyReg;
  logic [WORD_W-1:0] skipReg;
  logic [DEPTH-1:0]  cellMatch;
  logic [DEPTH-1:0]  tagReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyReg  <= '0;
      skipReg <= '0;
    end else begin
      if (loadKey)  keyReg  <= keyIn;
      if (loadSkip) skipReg <= skipIn;
    end
  end

  // One compare cell per entry, all fed the same key and mask.
  for (genvar i = 0; i < DEPTH; i++) begin : gCell
    camCell #(.WORD_W(WORD_W)) uCell (
      .clk      (clk),
      .rstN     (rstN),
      .wrSel    (wrEn && (wrIdx == IDX_W'(i))),
      .wrData   (wrData),
      .keyWord  (keyReg),
      .skipWord (skipReg),
      .matchBit (cellMatch[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    tagReg <= '0;
    else if (strobes.captureTags) tagReg <= cellMatch;
  end

  // Gathering stage: lowest set tag and population count.
  logic              gHit;
  logic [IDX_W-1:0]  gIdx;
  logic [CNT_W-1:0]  gCnt;

  always_comb begin
    gHit = 1'b0;
    gIdx = '0;
    gCnt = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (tagReg[i]) begin
        gHit = 1'b1;
        gIdx = IDX_W'(i);
        gCnt = gCnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hit      <= 1'b0;
      hitIdx   <= '0;
      hitCount <= '0;
    end else if (strobes.captureResult) begin
      hit      <= gHit;
      hitIdx   <= gIdx;
      hitCount <= gCnt;
    end
  end

endmodule

// File: rtl/maskedCam.sv
module maskedCam
  import maskedCamPkg::*;
#(
  parameter  int DEPTH  = 16,
  parameter  int HI_W   = 12,
  parameter  int MID_W  = 4,
  parameter  int LO_W   = 8,
  localparam int WORD_W = HI_W + MID_W + LO_W,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadKey,
  input  logic [WORD_W-1:0] keyIn,
  input  logic              loadSkip,
  input  logic [WORD_W-1:0] skipIn,
  input  logic              startSearch,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [WORD_W-1:0] wrData,
  output logic              busy,
  output logic              done,
  output logic              hit,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [CNT_W-1:0]  hitCount
);

  camStrobes_t strobes;

  camCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .startSearch (startSearch),
    .strobes     (strobes),
    .busy        (busy),
    .done        (done)
  );

  camDatapath #(
    .DEPTH  (DEPTH),
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .loadKey  (loadKey),
    .keyIn    (keyIn),
    .loadSkip (loadSkip),
    .skipIn   (skipIn),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .hit      (hit),
    .hitIdx   (hitIdx),
    .hitCount (hitCount)
  );

endmodule

// File: rtl/camChecker.sv
module camChecker #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             startSearch,
  input logic             busy,
  input logic             done,
  input logic             hit,
  input logic [IDX_W-1:0] hitIdx,
  input logic [CNT_W-1:0] hitCount
);

  assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (startSearch && !busy) |=> busy);

  assert_busy_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (done && !busy));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_hit_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (hit == (hitCount != '0)));

  assert_miss_idx_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !hit) |-> (hitIdx == '0));

  assert_count_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    hitCount <= CNT_W'(DEPTH));

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startSearch) |=> !busy);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(hit) && $stable(hitIdx) && $stable(hitCount)));

endmodule

bind maskedCam camChecker #(
  .DEPTH (DEPTH),
  .IDX_W (IDX_W),
  .CNT_W (CNT_W)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .startSearch (startSearch),
  .busy        (busy),
  .done        (done),
  .hit         (hit),
  .hitIdx      (hitIdx),
  .hitCount    (hitCount)
);

// File: tb/sim_maskedCam.sv
`timescale 1ns/1ps
module sim_maskedCam;

  localparam int DEPTH = 16;
  localparam int W     = 24;

  logic          clk = 1'b0;
  logic          rstN;
  logic          loadKey, loadSkip, startSearch, wrEn;
  logic [W-1:0]  keyIn, skipIn, wrData;
  logic [3:0]    wrIdx;
  logic          busy, done, hit;
  logic [3:0]    hitIdx;
  logic [4:0]    hitCount;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench model
  logic [W-1:0] mMem [DEPTH];
  bit           mVal [DEPTH];
  logic [W-1:0] mKey, mSkip;
  int eHit, eIdx, eCnt;

  always #5 clk = ~clk;

  maskedCam u0 (
    .clk(clk), .rstN(rstN), .loadKey(loadKey), .keyIn(keyIn),
    .loadSkip(loadSkip), .skipIn(skipIn), .startSearch(startSearch),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .busy(busy),
    .done(done), .hit(hit), .hitIdx(hitIdx), .hitCount(hitCount)
  );

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic calcExpect();
    eHit = 0; eIdx = 0; eCnt = 0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (mVal[i] && (((mMem[i] ^ mKey) & ~mSkip) == '0)) begin
        eHit = 1; eIdx = i; eCnt++;
      end
    end
  endtask

  task automatic doWrite(int idx, logic [W-1:0] d);
    wrEn = 1'b1; wrIdx = 4'(idx); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    mMem[idx] = d; mVal[idx] = 1;
  endtask

  task automatic loadRegs(logic [W-1:0] k, logic [W-1:0] s);
    loadKey = 1'b1; keyIn = k; loadSkip = 1'b1; skipIn = s;
    @(negedge clk);
    loadKey = 1'b0; loadSkip = 1'b0;
    mKey = k; mSkip = s;
  endtask

  // Runs one search; optional key load and write on the starting edge,
  // optional write and extra start in the busy cycle.
  task automatic runSearch(string tag, bit doLoad, logic [W-1:0] k,
                           bit doWr, int wi, logic [W-1:0] wd, bit extraStart);
    calcExpect();
    startSearch = 1'b1;
    if (doLoad) begin loadKey = 1'b1; keyIn = k; end
    if (doWr)   begin wrEn = 1'b1; wrIdx = 4'(wi); wrData = wd; end
    @(negedge clk);
    if (doLoad) mKey = k;
    if (doWr) begin mMem[wi] = wd; mVal[wi] = 1; end
    loadKey = 1'b0;
    startSearch = extraStart;
    if (doWr) begin wrIdx = 4'(wi ^ 1); mMem[wi ^ 1] = wd; mVal[wi ^ 1] = 1; end
    chk("R5", int'(busy), 1, "busy after start");
    chk("R5", int'(done), 0, "done early");
    @(negedge clk);
    startSearch = 1'b0; wrEn = 1'b0;
    chk("R5", int'(done), 1, "done pulse");
    chk(tag, int'(hit), eHit, "hit");
    chk(tag, int'(hitIdx), eIdx, "hitIdx");
    chk(tag, int'(hitCount), eCnt, "hitCount");
    @(negedge clk);
    chk("R10", int'(done), 0, "done after pulse");
    chk("R10", int'(busy), 0, "busy after pulse");
    chk("R10", int'(hitCount), eCnt, "result held");
  endtask

  function automatic logic [W-1:0] rndWord();
    return {12'(12'h0A0 + $urandom % 2), 4'($urandom % 3), 8'($urandom % 2)};
  endfunction

  function automatic logic [W-1:0] rndSkip();
    logic [W-1:0] s;
    s = {{12{$urandom % 2 == 0}}, {4{$urandom % 2 == 0}}, {8{$urandom % 2 == 0}}};
    if ($urandom % 5 == 0) s = s | W'($urandom);
    return s;
  endfunction

  initial begin
    int seedJunk;
    seedJunk = $urandom(32'd4321);
    rstN = 1'b0; loadKey = 0; loadSkip = 0; startSearch = 0; wrEn = 0;
    keyIn = '0; skipIn = '0; wrData = '0; wrIdx = '0;
    for (int i = 0; i < DEPTH; i++) begin mMem[i] = '0; mVal[i] = 0; end
    mKey = '0; mSkip = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", int'(busy), 0, "busy reset");
    chk("R1", int'(done), 0, "done reset");
    chk("R1", int'(hit), 0, "hit reset");
    chk("R1", int'(hitIdx), 0, "hitIdx reset");
    chk("R1", int'(hitCount), 0, "hitCount reset");

    // R1/R4: empty table misses even with everything ignored
    loadRegs('0, '1);
    runSearch("R1", 0, '0, 0, 0, '0, 0);

    doWrite(3, 24'hABC512);
    doWrite(9, 24'hABC712);
    doWrite(12, 24'h123599);
    loadRegs(24'hABC512, '0);
    runSearch("R3", 0, '0, 0, 0, '0, 0);          // exact: idx 3, count 1
    loadRegs(24'hABC512, 24'h000F00);
    runSearch("R3", 0, '0, 0, 0, '0, 0);          // mid field ignored: 3 and 9
    loadRegs(24'h000500, 24'hFFF0FF);
    runSearch("R3", 0, '0, 0, 0, '0, 0);          // mid field only: 3 and 12
    loadRegs(24'h000000, '1);
    runSearch("R4", 0, '0, 0, 0, '0, 0);          // all valid: count 3

    // R8: key loaded on the starting edge is not used by that search
    loadRegs(24'hABC512, '0);
    runSearch("R8", 1, 24'h123599, 0, 0, '0, 0);
    runSearch("R8", 0, '0, 0, 0, '0, 0);          // now finds idx 12

    // R9 + R10: write on start edge and in busy cycle, extra start in busy
    runSearch("R9", 0, '0, 1, 0, 24'h123599, 1);  // old result: idx 12
    runSearch("R9", 0, '0, 0, 0, '0, 0);          // now idx 0, count 3

    // R2: overwrite removes the old value
    doWrite(3, 24'h000000);
    loadRegs(24'hABC512, '0);
    runSearch("R2", 0, '0, 0, 0, '0, 0);          // miss

    // Random mix
    for (int n = 0; n < 120; n++) begin
      int nw;
      nw = int'($urandom % 3);
      for (int j = 0; j < nw; j++) doWrite(int'($urandom % DEPTH), rndWord());
      if ($urandom % 2 == 0) loadRegs(mMem[$urandom % DEPTH] ^ W'($urandom % 2), rndSkip());
      else loadRegs(rndWord(), rndSkip());
      runSearch("R3", 0, '0, ($urandom % 4 == 0), int'($urandom % DEPTH), rndWord(),
                ($urandom % 3 == 0));
    end

    // R7 boundary: full table of identical words
    for (int i = 0; i < DEPTH; i++) doWrite(i, 24'h5A5A5A);
    loadRegs(24'h5A5A5A, '0);
    runSearch("R7", 0, '0, 0, 0, '0, 0);
    chk("R7", int'(hitCount), DEPTH, "full count");
    loadRegs(24'h000000, '1);
    runSearch("R4", 0, '0, 0, 0, '0, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule